// File: doc/BRIEF.md
# Second-Level Page Table Walker

This block turns a device's I/O virtual address into a guest physical address. A request carries the requester's 16-bit source ID (bus in bits 15:8, device and function in bits 7:0), the IOVA and a read/write flag. With translation enabled, the walker fetches the root entry selected by the bus number. It then fetches the context entry selected by device and function. Last, it descends a four-level page table held in memory. Every table fetch goes out through a single memory read port, and only one fetch is outstanding at a time. The result is either a translated address together with the effective permissions, or a fault with a reason code.

Root and context entries are 128 bits wide. Page table entries are 64 bits wide. A large-page bit lets a walk end early with a 2 MB or 1 GB leaf. A context entry can select pass-through, which returns the IOVA unchanged without reading page tables. With translation disabled, every request is mapped to itself. The context entry also carries a fault-processing-disable bit. That bit travels out with any page-level fault, so that later fault recording can be suppressed. No translations are cached.

Top module: `dma_xlate_walker`

## Requirements
- R1: Fetches follow a fixed order.
  - The root entry is fetched first, as a 128-bit read at page_base(rootPtr) + bus*16.
  - The context entry is fetched next, as a 128-bit read at page_base(root bits ADDR_W-1:12) + devfn*16.
  - The page table levels follow, each as a 64-bit read at table + index*8.
  - Bit 0 of a root or context entry is its present bit.
- R2: A root entry with bit 0 clear ends the walk after that single read, with fault reason 0x01 and rspFpd low.
- R3: A context entry with bit 0 clear ends the walk after the two reads, with fault reason 0x02.
- R4: The walk visits four levels.
  - The index at level L is IOVA bits [12+9L-1 : 12+9(L-1)], so the top level uses bits 47:39.
  - Page entry bit 0 is read, bit 1 is write, and bits ADDR_W-1:12 hold the next table or page frame.
  - A level-1 leaf gives frame | IOVA[11:0].
- R5: Bit 7 of a page entry marks a large-page leaf.
  - At level 3 the result is frame[ADDR_W-1:30] | IOVA[29:0], a 1 GB page.
  - At level 2 the result is frame[ADDR_W-1:21] | IOVA[20:0], a 2 MB page.
  - No further levels are read after a large-page leaf.
- R6: On success, rspPerm reports the AND of the read bits (rspPerm[0]) and of the write bits (rspPerm[1]) over every level visited.
- R7: Permission faults end the walk at the level where they occur.
  - When the accumulated permission for the access is missing at a level, the walk stops there.
  - A read faults with reason 0x06; a write faults with reason 0x05.
  - An entry with both bits clear is treated the same way and has no reason code of its own.
- R8: A context entry whose bits 3:2 equal 2'b10 is pass-through. The walk returns the IOVA with rspPerm = 2'b11 and reads no page table entries.
- R9: With xlateEn low, the response comes in the cycle after acceptance. It carries rspAddr equal to the IOVA, rspPerm = 2'b11, and no fault, and no memory read is made.
- R10: Bit 1 of the context entry is the fault-processing-disable bit. It is output on rspFpd with any page-level fault. rspFpd is low on success and on root or context faults.
- R11: reqReady is high only while the block is idle and is low for the whole walk. rspValid is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Block idle, accepts a request |
| reqSrcId | input | 16 | Requester ID: bus[15:8], devfn[7:0] |
| reqIova | input | ADDR_W | I/O virtual address |
| reqWrite | input | 1 | 1 = write access, 0 = read |
| xlateEn | input | 1 | Translation enable |
| rootPtr | input | ADDR_W | Root table base (page aligned) |
| memReqValid | output | 1 | Table fetch strobe |
| memWide | output | 1 | 1 = 128-bit fetch, 0 = 64-bit fetch |
| memAddr | output | ADDR_W | Table fetch address |
| memRspValid | input | 1 | Fetch data valid |
| memRspData | input | 128 | Fetch data (64-bit fetches in bits 63:0) |
| rspValid | output | 1 | Result pulse |
| rspAddr | output | ADDR_W | Translated address |
| rspPerm | output | 2 | Effective permissions {write, read} |
| rspFault | output | 1 | Walk faulted |
| rspReason | output | 8 | Fault reason code |
| rspFpd | output | 1 | Fault processing disabled for this fault |

## Verification
The bench builds the walker with its defaults: ADDR_W = 48, four levels, 9 index bits per level, and large pages allowed at levels 3 and 2. With these values the top index reaches IOVA bits 47:39, and the 1 GB, 2 MB and 4 KB leaf forms can all be reached from one shared page table. A memory model with one cycle of response latency serves the tables. It logs every fetch address and width, so the bench can confirm both the order of the reads and the point where each walk stops after a fault.

// File: rtl/walk_pkg.sv
package walk_pkg;

  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT, S_DONE} ctrlState_e;
  typedef enum logic [1:0] {P_ROOT, P_CTX, P_PTE} walkPhase_e;

  // Strobes from control to datapath, one set per cycle.
  typedef struct packed {
    logic       capture;
    logic       takeRoot;
    logic       takeCtx;
    logic       takePte;
    logic       endIdentity;
    logic       endPassThru;
    logic       endLeaf;
    logic       endFault;
    logic [7:0] faultCode;
  } walkStrobe_t;

  localparam logic [7:0] FR_ROOT  = 8'h01;
  localparam logic [7:0] FR_CTX   = 8'h02;
  localparam logic [7:0] FR_WRITE = 8'h05;
  localparam logic [7:0] FR_READ  = 8'h06;

  localparam int ENT_PRESENT = 0;
  localparam int CTX_FPD     = 1;
  localparam int PTE_RD      = 0;
  localparam int PTE_WR      = 1;
  localparam int PTE_LARGE   = 7;
  localparam logic [1:0] CTX_PASS = 2'b10;

endpackage

// File: rtl/walk_datapath.sv
module walk_datapath
  import walk_pkg::*;
#(
  parameter int ADDR_W     = 48,
  parameter int LEVELS     = 4,
  parameter int LEVEL_BITS = 9,
  parameter int PAGE_SHIFT = 12,
  parameter int LARGE_TOP  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  walkStrobe_t       strobe,
  input  walkPhase_e        phase,
  input  logic [15:0]       reqSrcId,
  input  logic [ADDR_W-1:0] reqIova,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] rootPtr,
  input  logic [127:0]      memRspData,
  output logic [ADDR_W-1:0] memAddr,
  output logic              rootPresent,
  output logic              ctxPresent,
  output logic              ctxPassThru,
  output logic              pteDenied,
  output logic              pteLeaf,
  output logic [7:0]        deniedCode,
  output logic [ADDR_W-1:0] rspAddr,
  output logic [1:0]        rspPerm,
  output logic              rspFault,
  output logic [7:0]        rspReason,
  output logic              rspFpd
);

  localparam int LVL_W = $clog2(LEVELS + 1);

  logic [ADDR_W-1:0]     iovaQ, rootQ, ctxPtrQ, tablePtrQ;
  logic [15:0]           srcQ;
  logic                  writeQ, accR, accW, fpdQ;
  logic [LVL_W-1:0]      levelQ;

  int                    shiftV;
  logic [LEVEL_BITS-1:0] idx;
  logic [ADDR_W-1:0]     offMask, entryFrame, rootBase;

  always_comb begin
    shiftV     = PAGE_SHIFT + LEVEL_BITS * (int'(levelQ) - 1);
    idx        = LEVEL_BITS'(iovaQ >> shiftV);
    offMask    = (ADDR_W'(1) << shiftV) - ADDR_W'(1);
    entryFrame = {memRspData[ADDR_W-1:PAGE_SHIFT], {PAGE_SHIFT{1'b0}}};
    rootBase   = {rootQ[ADDR_W-1:PAGE_SHIFT], {PAGE_SHIFT{1'b0}}};
    case (phase)
      P_ROOT:  memAddr = rootBase + ADDR_W'({srcQ[15:8], 4'b0000});
      P_CTX:   memAddr = ctxPtrQ + ADDR_W'({srcQ[7:0], 4'b0000});
      default: memAddr = tablePtrQ + (ADDR_W'(idx) << 3);
    endcase
  end

  // Entry decode for the control
  assign rootPresent = memRspData[ENT_PRESENT];
  assign ctxPresent  = memRspData[ENT_PRESENT];
  assign ctxPassThru = (memRspData[3:2] == CTX_PASS);
  assign pteDenied   = writeQ ? !(accW & memRspData[PTE_WR]) : !(accR & memRspData[PTE_RD]);
  assign pteLeaf     = (levelQ == LVL_W'(1)) ||
                       (memRspData[PTE_LARGE] && levelQ > LVL_W'(1) && levelQ <= LVL_W'(LARGE_TOP));
  assign deniedCode  = writeQ ? FR_WRITE : FR_READ;

  logic unusedBits;
  assign unusedBits = &{1'b0, memRspData[127:ADDR_W], memRspData[PAGE_SHIFT-1:8],
                        memRspData[6:4], rootQ[PAGE_SHIFT-1:0]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      iovaQ <= '0; rootQ <= '0; ctxPtrQ <= '0; tablePtrQ <= '0;
      srcQ <= '0; writeQ <= 1'b0; accR <= 1'b0; accW <= 1'b0; fpdQ <= 1'b0;
      levelQ <= '0;
      rspAddr <= '0; rspPerm <= '0; rspFault <= 1'b0; rspReason <= '0; rspFpd <= 1'b0;
    end else begin
      if (strobe.capture) begin
        iovaQ <= reqIova; srcQ <= reqSrcId; writeQ <= reqWrite; rootQ <= rootPtr;
        accR <= 1'b1; accW <= 1'b1; fpdQ <= 1'b0;
        rspFault <= 1'b0; rspReason <= '0; rspFpd <= 1'b0;
      end
      if (strobe.takeRoot) ctxPtrQ <= entryFrame;
      if (strobe.takeCtx) begin
        tablePtrQ <= entryFrame;
        levelQ    <= LVL_W'(LEVELS);
        fpdQ      <= memRspData[CTX_FPD];
      end
      if (strobe.takePte) begin
        accR      <= accR & memRspData[PTE_RD];
        accW      <= accW & memRspData[PTE_WR];
        tablePtrQ <= entryFrame;
        levelQ    <= levelQ - LVL_W'(1);
      end
      if (strobe.endIdentity) begin
        rspAddr <= reqIova; rspPerm <= 2'b11;
      end
      if (strobe.endPassThru) begin
        rspAddr <= iovaQ; rspPerm <= 2'b11;
      end
      if (strobe.endLeaf) begin
        rspAddr  <= (entryFrame & ~offMask) | (iovaQ & offMask);
        rspPerm  <= {accW & memRspData[PTE_WR], accR & memRspData[PTE_RD]};
        rspFault <= 1'b0; rspFpd <= 1'b0;
      end
      if (strobe.endFault) begin
        rspAddr <= '0; rspPerm <= 2'b00;
        rspFault <= 1'b1; rspReason <= strobe.faultCode; rspFpd <= fpdQ;
      end
    end
  end

  // R6: a granted leaf always carries the permission the access asked for
  assert_perm_grant_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.endLeaf |=> (!rspFault && (writeQ ? rspPerm[1] : rspPerm[0])));

  // R7 (with R2, R3): only the defined reason codes leave a faulted walk
  assert_fault_code_R7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.endFault |=> (rspFault && (rspReason == FR_ROOT || rspReason == FR_CTX ||
                                      rspReason == FR_WRITE || rspReason == FR_READ)));

endmodule

// File: rtl/walk_ctrl.sv
module walk_ctrl
  import walk_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        xlateEn,
  input  logic        memRspValid,
  input  logic        rootPresent,
  input  logic        ctxPresent,
  input  logic        ctxPassThru,
  input  logic        pteDenied,
  input  logic        pteLeaf,
  input  logic [7:0]  deniedCode,
  output walkStrobe_t strobe,
  output walkPhase_e  phase,
  output logic        reqReady,
  output logic        memReqValid,
  output logic        memWide,
  output logic        rspValid
);

  ctrlState_e state, nextState;
  walkPhase_e nextPhase;

  always_comb begin
    strobe      = '0;
    nextState   = state;
    nextPhase   = phase;
    reqReady    = (state == S_IDLE);
    memReqValid = (state == S_ISSUE);
    memWide     = (phase != P_PTE);
    rspValid    = (state == S_DONE);
    case (state)
      S_IDLE: if (reqValid) begin
        strobe.capture = 1'b1;
        if (!xlateEn) begin
          strobe.endIdentity = 1'b1;
          nextState = S_DONE;
        end else begin
          nextPhase = P_ROOT;
          nextState = S_ISSUE;
        end
      end
      S_ISSUE: nextState = S_WAIT;
      S_WAIT: if (memRspValid) begin
        case (phase)
          P_ROOT: if (!rootPresent) begin
            strobe.endFault = 1'b1; strobe.faultCode = FR_ROOT; nextState = S_DONE;
          end else begin
            strobe.takeRoot = 1'b1; nextPhase = P_CTX; nextState = S_ISSUE;
          end
          P_CTX: if (!ctxPresent) begin
            strobe.endFault = 1'b1; strobe.faultCode = FR_CTX; nextState = S_DONE;
          end else begin
            strobe.takeCtx = 1'b1;
            if (ctxPassThru) begin
              strobe.endPassThru = 1'b1; nextState = S_DONE;
            end else begin
              nextPhase = P_PTE; nextState = S_ISSUE;
            end
          end
          default: if (pteDenied) begin
            strobe.endFault = 1'b1; strobe.faultCode = deniedCode; nextState = S_DONE;
          end else if (pteLeaf) begin
            strobe.endLeaf = 1'b1; nextState = S_DONE;
          end else begin
            strobe.takePte = 1'b1; nextState = S_ISSUE;
          end
        endcase
      end
      default: nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE;
      phase <= P_ROOT;
    end else begin
      state <= nextState;
      phase <= nextPhase;
    end
  end

  // R11: no table fetch while the block advertises itself idle
  assert_busy_R11: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |-> !reqReady);

  // R11: the result is a one-cycle pulse
  assert_pulse_R11: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid);

endmodule

// File: rtl/dma_xlate_walker.sv
module dma_xlate_walker
  import walk_pkg::*;
#(
  parameter int ADDR_W     = 48,
  parameter int LEVELS     = 4,
  parameter int LEVEL_BITS = 9,
  parameter int PAGE_SHIFT = 12,
  parameter int LARGE_TOP  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [15:0]       reqSrcId,
  input  logic [ADDR_W-1:0] reqIova,
  input  logic              reqWrite,
  input  logic              xlateEn,
  input  logic [ADDR_W-1:0] rootPtr,
  output logic              memReqValid,
  output logic              memWide,
  output logic [ADDR_W-1:0] memAddr,
  input  logic              memRspValid,
  input  logic [127:0]      memRspData,
  output logic              rspValid,
  output logic [ADDR_W-1:0] rspAddr,
  output logic [1:0]        rspPerm,
  output logic              rspFault,
  output logic [7:0]        rspReason,
  output logic              rspFpd
);

  walkStrobe_t strobe;
  walkPhase_e  phase;
  logic        rootPresent, ctxPresent, ctxPassThru, pteDenied, pteLeaf;
  logic [7:0]  deniedCode;

  walk_ctrl u_ctrl (
    .clk, .rstN, .reqValid, .xlateEn, .memRspValid,
    .rootPresent, .ctxPresent, .ctxPassThru, .pteDenied, .pteLeaf, .deniedCode,
    .strobe, .phase, .reqReady, .memReqValid, .memWide, .rspValid
  );

  walk_datapath #(
    .ADDR_W(ADDR_W), .LEVELS(LEVELS), .LEVEL_BITS(LEVEL_BITS),
    .PAGE_SHIFT(PAGE_SHIFT), .LARGE_TOP(LARGE_TOP)
  ) u_dp (
    .clk, .rstN, .strobe, .phase, .reqSrcId, .reqIova, .reqWrite, .rootPtr, .memRspData,
    .memAddr, .rootPresent, .ctxPresent, .ctxPassThru, .pteDenied, .pteLeaf, .deniedCode,
    .rspAddr, .rspPerm, .rspFault, .rspReason, .rspFpd
  );

  // R9: translation off maps one-to-one with a response on the next cycle
  assert_identity_R9: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && !xlateEn) |=> (rspValid && !rspFault && rspAddr == $past(reqIova)));

endmodule

// File: tb/dma_xlate_walker_bench.sv
`timescale 1ns/1ps
module dma_xlate_walker_bench;

  localparam int AW = 48;

  logic clk = 1'b0, rstN = 1'b0;
  logic reqValid = 1'b0, reqWrite = 1'b0, xlateEn = 1'b1;
  logic [15:0] reqSrcId = '0;
  logic [AW-1:0] reqIova = '0, rootPtr = 48'h10000;
  logic memRspValid = 1'b0;
  logic [127:0] memRspData = '0;
  logic reqReady, memReqValid, memWide, rspValid, rspFault, rspFpd;
  logic [AW-1:0] memAddr, rspAddr;
  logic [1:0] rspPerm;
  logic [7:0] rspReason;

  always #10 clk = ~clk;

  dma_xlate_walker u_dma_xlate_walker (
    .clk, .rstN, .reqValid, .reqReady, .reqSrcId, .reqIova, .reqWrite, .xlateEn, .rootPtr,
    .memReqValid, .memWide, .memAddr, .memRspValid, .memRspData,
    .rspValid, .rspAddr, .rspPerm, .rspFault, .rspReason, .rspFpd
  );

  int checks = 0, failures = 0;
  bit [63:0] mem [longint unsigned];
  int nReads;
  logic [AW-1:0] readAddr [0:15];
  logic readWide [0:15];
  logic pendQ = 1'b0;
  logic [127:0] pendData;

  logic [AW-1:0] gotAddr; logic [1:0] gotPerm; logic gotFault, gotFpd; logic [7:0] gotReason;
  int waitCycles; logic busySeen, pulseOk;

  function automatic bit [63:0] rd64(longint unsigned a);
    return mem.exists(a) ? mem[a] : 64'h0;
  endfunction

  // Memory model: one cycle of latency, logs every fetch
  always @(negedge clk) begin
    if (pendQ) begin memRspValid = 1'b1; memRspData = pendData; pendQ = 1'b0; end
    else memRspValid = 1'b0;
    if (memReqValid) begin
      if (nReads < 16) begin readAddr[nReads] = memAddr; readWide[nReads] = memWide; end
      nReads++;
      pendData = memWide ? {rd64((memAddr >> 3) + 1), rd64(memAddr >> 3)}
                         : {64'h0, rd64(memAddr >> 3)};
      pendQ = 1'b1;
    end
  end

  task automatic check(string tag, logic [63:0] got, logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic put64(logic [AW-1:0] a, bit [63:0] v); mem[a >> 3] = v; endtask
  task automatic put128(logic [AW-1:0] a, bit [63:0] lo); mem[a >> 3] = lo; mem[(a >> 3) + 1] = 64'h0; endtask

  function automatic logic [AW-1:0] mkIova(int i4, int i3, int i2, int i1, int off);
    return (AW'(i4) << 39) | (AW'(i3) << 30) | (AW'(i2) << 21) | (AW'(i1) << 12) | AW'(off);
  endfunction

  task automatic runReq(logic [15:0] src, logic [AW-1:0] iova, logic wr);
    @(negedge clk);
    nReads = 0; reqSrcId = src; reqIova = iova; reqWrite = wr; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0; busySeen = 1'b0; waitCycles = 0;
    while (!rspValid) begin
      if (!reqReady) busySeen = 1'b1;
      @(negedge clk); waitCycles++;
    end
    gotAddr = rspAddr; gotPerm = rspPerm; gotFault = rspFault; gotReason = rspReason; gotFpd = rspFpd;
    @(negedge clk);
    pulseOk = !rspValid;
  endtask

  task automatic buildTables();
    put128(48'h10030, 64'h20001);              // bus 3 root
    put128(48'h200A0, 64'h30001);              // devfn 0A translated
    put128(48'h200B0, 64'h30009);              // devfn 0B pass-through
    put128(48'h200C0, 64'h30003);              // devfn 0C fpd set
    put64(48'h30008, 64'h31003);               // L4 idx1
    put64(48'h31010, 64'h32003);               // L3 idx2
    put64(48'h31038, 64'h40_0000_0083);        // L3 idx7: 1 GB leaf
    put64(48'h32018, 64'h33003);               // L2 idx3
    put64(48'h32028, 64'h8_0020_0083);         // L2 idx5: 2 MB leaf
    put64(48'h32030, 64'h34001);               // L2 idx6: read only
    put64(48'h33020, 64'h7654_3003);           // L1 idx4
    put64(48'h34020, 64'h5555_5003);           // L1 idx4 under read-only table
  endtask

  task automatic testReset();
    check("R11 reset reqReady", reqReady, 1);
    check("R11 reset rspValid", rspValid, 0);
    check("R1 reset memReqValid", memReqValid, 0);
  endtask

  task automatic testIdentity();
    xlateEn = 1'b0;
    runReq(16'h0500, 48'hABCD_1234_5678, 1'b1);
    check("R9 identity addr", gotAddr, 48'hABCD_1234_5678);
    check("R9 identity perm", gotPerm, 2'b11);
    check("R9 identity fault", gotFault, 0);
    check("R9 identity reads", nReads, 0);
    check("R9 identity latency", waitCycles, 0);
    xlateEn = 1'b1;
  endtask

  task automatic testWalk4k();
    runReq(16'h030A, mkIova(1, 2, 3, 4, 12'hABC), 1'b1);
    check("R4 4K addr", gotAddr, 48'h7654_3ABC);
    check("R4 4K fault", gotFault, 0);
    check("R4 4K reads", nReads, 6);
    check("R1 root addr", readAddr[0], 48'h10030);
    check("R1 root wide", readWide[0], 1);
    check("R1 ctx addr", readAddr[1], 48'h200A0);
    check("R1 top pte addr", readAddr[2], 48'h30008);
    check("R1 pte narrow", readWide[2], 0);
    check("R4 last pte addr", readAddr[5], 48'h33020);
    check("R10 fpd on success", gotFpd, 0);
    check("R11 busy during walk", busySeen, 1);
    check("R11 single pulse", pulseOk, 1);
  endtask

  task automatic testLarge();
    runReq(16'h030A, mkIova(1, 2, 5, 6, 12'h123), 1'b0);
    check("R5 2M addr", gotAddr, 48'h8_0020_6123);
    check("R5 2M reads", nReads, 5);
    runReq(16'h030A, mkIova(1, 7, 9'h1AB, 9'h0CD, 12'h456), 1'b0);
    check("R5 1G addr", gotAddr, 48'h40_0000_0000 | (48'h1AB << 21) | (48'h0CD << 12) | 48'h456);
    check("R5 1G reads", nReads, 4);
  endtask

  task automatic testPermAnd();
    runReq(16'h030A, mkIova(1, 2, 6, 4, 12'h010), 1'b0);
    check("R6 and read addr", gotAddr, 48'h5555_5010);
    check("R6 and perm", gotPerm, 2'b01);
    runReq(16'h030A, mkIova(1, 2, 6, 4, 12'h010), 1'b1);
    check("R7 write denied code", gotReason, 8'h05);
    check("R7 write denied stops", nReads, 5);
  endtask

  task automatic testNotPresent();
    runReq(16'h030A, mkIova(1, 2, 3, 9, 0), 1'b0);
    check("R7 np read fault", gotFault, 1);
    check("R7 np read code", gotReason, 8'h06);
    check("R10 fpd clear", gotFpd, 0);
    runReq(16'h030A, mkIova(1, 2, 3, 9, 0), 1'b1);
    check("R7 np write code", gotReason, 8'h05);
  endtask

  task automatic testRootCtx();
    runReq(16'h0500, 48'h1000, 1'b0);
    check("R2 root code", gotReason, 8'h01);
    check("R2 root reads", nReads, 1);
    check("R2 root fpd", gotFpd, 0);
    runReq(16'h0311, 48'h1000, 1'b0);
    check("R3 ctx code", gotReason, 8'h02);
    check("R3 ctx reads", nReads, 2);
  endtask

  task automatic testPassThru();
    runReq(16'h030B, 48'h1234_5678_9ABC, 1'b1);
    check("R8 pass addr", gotAddr, 48'h1234_5678_9ABC);
    check("R8 pass perm", gotPerm, 2'b11);
    check("R8 pass fault", gotFault, 0);
    check("R8 pass reads", nReads, 2);
  endtask

  task automatic testFpd();
    runReq(16'h030C, mkIova(1, 2, 3, 9, 0), 1'b0);
    check("R10 fpd code", gotReason, 8'h06);
    check("R10 fpd propagated", gotFpd, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, failures);
    $finish;
  end

  initial begin
    nReads = 0;
    buildTables();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testIdentity();
    testWalk4k();
    testLarge();
    testPermAnd();
    testNotPresent();
    testRootCtx();
    testPassThru();
    testFpd();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, failures);
    $finish;
  end

endmodule